// File: doc/BRIEF.md
# Byte-Register Doorbell Bridge to a 32-bit System Bus

This block gives an 8-bit microcontroller a way to make single reads and writes on a 32-bit system bus. The controller sees the bridge as a small bank of byte-wide special function registers. It loads a target address and write data one byte at a time. It then writes a control byte that holds the transfer width, the direction and a go bit. The bridge raises a request on the bus and keeps the go bit reading as 1 until the bus accepts the request. It then clears the bit by itself and, for a read, leaves the returned bytes in a read-only group of registers.

Software polls the go bit and never needs an interrupt. The bridge aligns narrow writes onto the correct byte lanes and produces the matching byte strobes. It also moves narrow read results down to the least significant byte. Every register write that arrives while a transfer is pending is dropped, so the bus sees a stable request.

Top module: `sfr_bus_bridge`

## Requirements
- R1: After reset `bus_valid` is 0, and every register selector from 0 to 12 reads back 0.
- R2: Selector 0 is the control byte, with bit 0 the go bit, bit 1 the write flag and bits 3:2 the size. Selectors 1 to 4 hold address bytes 0 to 3, and selectors 5 to 8 hold write-data bytes 0 to 3. Selectors 9 to 12 hold read-data bytes 0 to 3, least significant first. The control byte reads back the stored size and write flag, with the go bit in bit 0.
- R3: A control write with bit 0 set, made while idle, raises `bus_valid` in the cycle after that write's clock edge. In that same cycle `bus_write` equals the written bit 1.
- R4: The go bit reads 1 from the cycle after the starting edge until the edge on which `bus_valid` and `bus_ready` are both high. It reads 0 from the cycle after that edge.
- R5: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high in the next cycle. `bus_addr`, `bus_wdata`, `bus_strb` and `bus_write` also keep their values.
- R6: In the cycle after a handshake edge `bus_valid` is 0.
- R7: Size 0 (byte) gives strobe `1 << addr[1:0]`. Size 1 (halfword) gives `3 << (2*addr[1])`. Size 2 (word) and the spare code 3 give `4'b1111`.
- R8: `bus_wdata` carries the low bytes of the write-data register. They start at byte lane 0 for a word, lane `2*addr[1]` for a halfword, or lane `addr[1:0]` for a byte.
- R9: On a read handshake edge, the bridge shifts `bus_rdata` right by that same lane base and clears every byte above the transfer size. It stores the result in the read-data registers.
- R10: Writes to any register while the go bit reads 1 change no stored value and start nothing.
- R11: A control write with bit 0 clear stores the size and the write flag, and starts no bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_sel | input | 4 | Register selector |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write byte |
| sfr_rdata | output | 8 | Register read byte, combinational on `sfr_sel` |
| bus_valid | output | 1 | Request pending |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_strb | output | 4 | Byte strobes |
| bus_ready | input | 1 | Target accepts the request |
| bus_rdata | input | 32 | Read data, sampled at the handshake edge |

## Verification
A control write sampled at edge N shows up as `bus_valid` and as a go bit of 1 in the cycle after N. The bench therefore reads both half a cycle after that edge, before it makes any other access. The bus model raises `bus_ready` after a wait of zero to three cycles. The handshake edge clears the go bit and loads the read-data registers together, so the bench checks the cleared bit, the low `bus_valid` and the read bytes only at the falling edge after that handshake. A sweep over direction, size and all four low address values compares strobes, data lanes and read results with values the bench computes from the alignment rules.

// File: rtl/sfrb_pkg.sv
package sfrb_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;
  localparam int LANE_W = $clog2(NBYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  // first byte lane touched by a transfer of this size at this address
  function automatic logic [LANE_W-1:0] lane_base(xfer_size_e sz, logic [LANE_W-1:0] lo);
    case (sz)
      SZ_BYTE: return lo;
      SZ_HALF: return {lo[LANE_W-1:1], 1'b0};
      default: return '0;
    endcase
  endfunction

  // byte-enable pattern before shifting to the lane base
  function automatic logic [NBYTES-1:0] size_mask(xfer_size_e sz);
    case (sz)
      SZ_BYTE: return NBYTES'(1);
      SZ_HALF: return NBYTES'(3);
      default: return '1;
    endcase
  endfunction

  function automatic logic [NBYTES-1:0] strobe_for(xfer_size_e sz, logic [LANE_W-1:0] lo);
    return size_mask(sz) << lane_base(sz, lo);
  endfunction

  function automatic logic [DATA_W-1:0] byte_expand(logic [NBYTES-1:0] m);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] place_wdata(xfer_size_e sz, logic [LANE_W-1:0] lo,
                                                    logic [DATA_W-1:0] d);
    return d << {lane_base(sz, lo), 3'b000};
  endfunction

  function automatic logic [DATA_W-1:0] extract_rdata(xfer_size_e sz, logic [LANE_W-1:0] lo,
                                                      logic [DATA_W-1:0] d);
    return (d >> {lane_base(sz, lo), 3'b000}) & byte_expand(size_mask(sz));
  endfunction

endpackage

// File: rtl/sfrb_regs.sv
module sfrb_regs
  import sfrb_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sfr_sel,
  input  logic               sfr_we,
  input  logic [7:0]         sfr_wdata,
  input  logic               busy,
  input  logic [DATA_W-1:0]  rd_word,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [DATA_W-1:0]  wdata_q,
  output xfer_size_e         size_q,
  output logic               write_q,
  output logic               start_evt,
  output logic [7:0]         sfr_rdata
);

  localparam int ABYTES     = ADDR_W / 8;
  localparam int SEL_CTRL   = 0;
  localparam int SEL_ADDR0  = 1;
  localparam int SEL_WDATA0 = SEL_ADDR0 + ABYTES;
  localparam int SEL_RDATA0 = SEL_WDATA0 + NBYTES;

  // accepted register write: anything arriving while busy is dropped
  logic wr_ok;
  logic ctrl_hit;
  assign wr_ok     = sfr_we && !busy;
  assign ctrl_hit  = wr_ok && (sfr_sel == SEL_W'(SEL_CTRL));
  assign start_evt = ctrl_hit && sfr_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
    end else if (ctrl_hit) begin
      size_q  <= xfer_size_e'(sfr_wdata[3:2]);
      write_q <= sfr_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < ABYTES; i++)
        if (sfr_sel == SEL_W'(SEL_ADDR0 + i)) addr_q[8*i +: 8] <= sfr_wdata;
      for (int i = 0; i < NBYTES; i++)
        if (sfr_sel == SEL_W'(SEL_WDATA0 + i)) wdata_q[8*i +: 8] <= sfr_wdata;
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (sfr_sel == SEL_W'(SEL_CTRL)) sfr_rdata = {4'b0000, size_q, write_q, busy};
    for (int i = 0; i < ABYTES; i++)
      if (sfr_sel == SEL_W'(SEL_ADDR0 + i)) sfr_rdata = addr_q[8*i +: 8];
    for (int i = 0; i < NBYTES; i++) begin
      if (sfr_sel == SEL_W'(SEL_WDATA0 + i)) sfr_rdata = wdata_q[8*i +: 8];
      if (sfr_sel == SEL_W'(SEL_RDATA0 + i)) sfr_rdata = rd_word[8*i +: 8];
    end
  end

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sfr_we |=> $stable(addr_q) && $stable(wdata_q) && $stable(size_q) && $stable(write_q));

  // R10
  no_start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);

endmodule

// File: rtl/sfrb_master.sv
module sfrb_master
  import sfrb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_evt,
  input  logic [ADDR_W-1:0]  addr_q,
  input  logic [DATA_W-1:0]  wdata_q,
  input  xfer_size_e         size_q,
  input  logic               write_q,
  input  logic               bus_ready,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               busy,
  output logic               bus_valid,
  output logic               bus_write,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  output logic [NBYTES-1:0]  bus_strb,
  output logic [DATA_W-1:0]  rd_word
);

  typedef enum logic {ST_IDLE = 1'b0, ST_REQ = 1'b1} mstate_e;
  mstate_e state_q;

  logic done_evt;
  logic rd_done_evt;
  assign bus_valid   = (state_q == ST_REQ);
  assign busy        = bus_valid;
  assign done_evt    = bus_valid && bus_ready;
  assign rd_done_evt = done_evt && !write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state_q <= ST_IDLE;
    else if (state_q == ST_IDLE) state_q <= start_evt ? ST_REQ : ST_IDLE;
    else if (bus_ready)          state_q <= ST_IDLE;
  end

  // the request is taken straight from the registers, which cannot change while busy
  assign bus_addr  = addr_q;
  assign bus_write = write_q;
  assign bus_strb  = strobe_for(size_q, addr_q[LANE_W-1:0]);
  assign bus_wdata = place_wdata(size_q, addr_q[LANE_W-1:0], wdata_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_word <= '0;
    else if (rd_done_evt) rd_word <= extract_rdata(size_q, addr_q[LANE_W-1:0], bus_rdata);
  end

  // R3
  start_raises_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> bus_valid);

  // R5
  request_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata)
                                && $stable(bus_strb) && $stable(bus_write));

  // R6
  idle_after_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !bus_valid);

  // R7
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && size_q == SZ_BYTE |-> $countones(bus_strb) == 1);

  // R9
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_evt |=> rd_word == extract_rdata($past(size_q), $past(addr_q[LANE_W-1:0]),
                                             $past(bus_rdata)));

endmodule

// File: rtl/sfr_bus_bridge.sv
module sfr_bus_bridge
  import sfrb_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sfr_sel,
  input  logic              sfr_we,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [31:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [3:0]        bus_strb,
  input  logic              bus_ready,
  input  logic [31:0]       bus_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_word;
  xfer_size_e        size_q;
  logic              write_q;
  logic              start_evt;
  logic              busy;

  sfrb_regs #(.SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_sel   (sfr_sel),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .busy      (busy),
    .rd_word   (rd_word),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .size_q    (size_q),
    .write_q   (write_q),
    .start_evt (start_evt),
    .sfr_rdata (sfr_rdata)
  );

  sfrb_master u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .size_q    (size_q),
    .write_q   (write_q),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_strb  (bus_strb),
    .rd_word   (rd_word)
  );

  // R4
  go_bit_tracks_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (sfr_sel != '0) || sfr_rdata[0]);

endmodule

// File: tb/sfr_bus_bridge_test.sv
module sfr_bus_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sfr_sel = '0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_strb;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2 clk = ~clk;

  sfr_bus_bridge uut (
    .clk(clk), .rst_n(rst_n), .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [16];
  int          cur_delay = 0;
  int          wcnt = 0;
  int          stab_err = 0;
  logic        txn_done = 1'b0;
  logic        valid_after_hs = 1'b0;
  logic [31:0] obs_addr, obs_wdata;
  logic [3:0]  obs_strb;
  logic        obs_write;

  // bus target model, acting on falling edges only
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      valid_after_hs = bus_valid;
      if (obs_write)
        for (int k = 0; k < 4; k++)
          if (obs_strb[k]) mem[obs_addr[5:2]][8*k +: 8] = obs_wdata[8*k +: 8];
      wcnt = 0;
      txn_done = 1'b1;
    end else if (bus_valid) begin
      if (wcnt == 0) begin
        obs_addr = bus_addr; obs_wdata = bus_wdata; obs_strb = bus_strb; obs_write = bus_write;
      end else if (bus_addr !== obs_addr || bus_wdata !== obs_wdata ||
                   bus_strb !== obs_strb || bus_write !== obs_write) begin
        stab_err++;
      end
      if (wcnt == cur_delay) begin
        bus_ready = 1'b1;
        bus_rdata = mem[bus_addr[5:2]];
      end
      wcnt++;
    end else begin
      wcnt = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [3:0] s, input logic [7:0] d);
    sfr_sel = s; sfr_wdata = d; sfr_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  // reads without waiting for an edge; caller is just past a falling edge
  task automatic sfr_peek(input logic [3:0] s, output logic [7:0] v);
    sfr_sel = s;
    #0.5;
    v = sfr_rdata;
  endtask

  task automatic sfr_read(input logic [3:0] s, output logic [7:0] v);
    @(negedge clk);
    sfr_peek(s, v);
  endtask

  function automatic int base_of(int sz, logic [1:0] lo);
    if (sz == 0) return int'(lo);
    if (sz == 1) return lo[1] ? 2 : 0;
    return 0;
  endfunction

  function automatic int width_of(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  task automatic run_txn(input logic [31:0] a, input logic [31:0] wd, input int sz,
                         input logic we, input int dly);
    logic [7:0]  v;
    logic [31:0] rd, exp_word, exp_rd, exp_wd;
    logic [3:0]  exp_strb;
    int          b, n, guard;
    b = base_of(sz, a[1:0]);
    n = width_of(sz);
    exp_word = mem[a[5:2]];
    exp_strb = '0; exp_wd = '0; exp_rd = '0;
    for (int k = 0; k < n; k++) begin
      exp_strb[b+k] = 1'b1;
      exp_wd[8*(b+k) +: 8] = wd[8*k +: 8];
      exp_rd[8*k +: 8] = exp_word[8*(b+k) +: 8];
    end
    for (int k = 0; k < 4; k++) sfr_write(4'(1 + k), a[8*k +: 8]);
    for (int k = 0; k < 4; k++) sfr_write(4'(5 + k), wd[8*k +: 8]);
    cur_delay = dly; stab_err = 0; txn_done = 1'b0;
    sfr_write(4'd0, {4'b0000, 2'(sz), we, 1'b1});
    // one cycle after the starting edge
    sfr_peek(4'd0, v);
    check("R4 go bit high while pending", 32'(v[0]), 32'd1);
    check("R3 valid after start", 32'(bus_valid), 32'd1);
    check("R3 write flag on bus", 32'(bus_write), 32'(we));
    // must be dropped: the request is still outstanding at this edge
    sfr_write(4'd1, ~a[7:0]);
    guard = 0;
    while (!txn_done && guard < 40) begin @(negedge clk); guard++; end
    check("R6 valid low after handshake", 32'(valid_after_hs), 32'd0);
    check("R5 request stable while waiting", 32'(stab_err), 32'd0);
    check("R7 strobes", 32'(obs_strb), 32'(exp_strb));
    check("R2 address on bus", obs_addr, a);
    sfr_peek(4'd0, v);
    check("R4 go bit cleared", 32'(v), {28'd0, 2'(sz), we, 1'b0});
    if (we) begin
      for (int k = 0; k < 4; k++)
        if (exp_strb[k]) check("R8 write lane", 32'(obs_wdata[8*k +: 8]), 32'(exp_wd[8*k +: 8]));
    end else begin
      for (int k = 0; k < 4; k++) begin
        sfr_read(4'(9 + k), v);
        rd[8*k +: 8] = v;
      end
      check("R9 read data", rd, exp_rd);
    end
    sfr_read(4'd1, v);
    check("R10 busy write ignored", 32'(v), 32'(a[7:0]));
    @(negedge clk);
  endtask

  logic finished = 1'b0;

  initial begin
    #(150000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 16; i++) mem[i] = 32'h8C41_2A07 ^ (32'(i) * 32'h0113_1F3B);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", 32'(bus_valid), 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 13; s++) begin
      sfr_read(4'(s), v);
      check("R1 register after reset", 32'(v), 32'd0);
    end
    // R11: control write without go bit
    sfr_write(4'd0, 8'b0000_1010);
    check("R11 no transfer from plain control write", 32'(bus_valid), 32'd0);
    repeat (2) @(negedge clk);
    check("R11 still idle", 32'(bus_valid), 32'd0);
    sfr_peek(4'd0, v);
    check("R2 control readback", 32'(v), 32'h0A);
    // R2: address and data byte readback
    sfr_write(4'd3, 8'h5C);
    sfr_write(4'd7, 8'hE1);
    sfr_read(4'd3, v);
    check("R2 address byte 2", 32'(v), 32'h5C);
    sfr_read(4'd7, v);
    check("R2 data byte 2", 32'(v), 32'hE1);
    // sweep direction, size, low address bits and wait length
    for (int we = 1; we >= 0; we--)
      for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 4; lo++)
          run_txn(32'h4000_0000 | 32'(((sz * 4 + lo + we * 5) % 16) << 2) | 32'(lo),
                  32'hD3B2_9A61 ^ 32'(sz * 32'h0101_0101 + lo * 32'h1100_0011),
                  sz, we[0], (lo + sz + we) % 4);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule